// File: doc/BRIEF.md
# Panel Control Pulse Generator

This block sits between the operator panel of a small stored-program machine and its timing logic. It takes two pushbuttons, clear and continue, and turns each press into exactly one clean pulse that lasts one clock cycle. Each button is a changeover switch with a make contact and a break contact, both active low. A set/reset state element per button removes contact bounce. A short synchroniser chain then brings the debounced level into the clock domain. A registered rising-edge detector emits the pulse.

The block also holds the run flip-flop. A continue pulse starts the machine. Panel pulses are generated only while the machine is halted, so a clear press cannot stop a running machine. To halt a running machine, the single-step input is raised, and the run flip-flop drops at the next end-of-instruction strobe. After that, clear and continue work again. The power-on reset puts the machine in the halted state.

Top module: `fp_ctrl_pulse`

## Requirements
- R1: During and directly after reset, run_o is 0, clr_pulse_o is 0, clr_pulse_no is 1 and cont_pulse_no is 1.
- R2: A clear press that starts on the cycle after a sampling point gives clr_pulse_o high for exactly one cycle. It is high SYNC_STAGES+2 rising edges after the contact change, and clr_pulse_no is its exact complement in every cycle.
- R3: A continue press gives cont_pulse_no low for exactly one cycle, with the same SYNC_STAGES+2 edge latency as R2.
- R4: Each button's debounced state has these rules. Make low with break high means pressed. Break low with make high means released. Both contacts high (in transit) holds the state, and both contacts low holds the state. A press that bounces between make-low and both-high gives one pulse.
- R5: A button held pressed for any length of time gives one pulse. A new pulse needs a release followed by a new press.
- R6: While run_o is 1, no clear or continue pulse is generated, and a clear press does not change run_o. A button that is still held when the machine halts gives no pulse until it has been released and pressed again.
- R7: A continue pulse sets run_o to 1 on the next rising edge.
- R8: While run_o is 1, step_i high together with instr_end_i high clears run_o on that edge. step_i high alone leaves run_o unchanged.
- R9: Repeated press and release cycles give one pulse per press, every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| clr_make_ni | input | 1 | Clear button make contact, low when pressed |
| clr_break_ni | input | 1 | Clear button break contact, low when released |
| cont_make_ni | input | 1 | Continue button make contact, low when pressed |
| cont_break_ni | input | 1 | Continue button break contact, low when released |
| step_i | input | 1 | Single-step request, halts at the end of the instruction |
| instr_end_i | input | 1 | End-of-instruction strobe from the timing logic |
| clr_pulse_no | output | 1 | Clear pulse, active low |
| clr_pulse_o | output | 1 | Clear pulse, active high |
| cont_pulse_no | output | 1 | Continue pulse, active low |
| run_o | output | 1 | Run flip-flop, 1 while the machine is running |

## Verification
A debounce state stuck at the wrong value shows up at the pulse ports in one of two ways. Either a press is missing, or a second pulse appears after a bounce or after an illegal contact pair, within SYNC_STAGES+2 cycles of the contact change. A stale edge-detector history would show as a second pulse on a held button, or as a pulse when a held button becomes visible after a step halt. A run flip-flop in the wrong state shows at once on run_o, and on the next press as a pulse that is wrongly present or wrongly missing. The bench therefore counts pulses across whole press windows and checks the exact latency edge and the cycle after it.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int NUM_BTN      = 2;
  localparam int BTN_CLR      = 0;
  localparam int BTN_CONT     = 1;
  localparam int SYNC_DEFAULT = 2;
endpackage

// File: rtl/fp_contact_latch.sv
module fp_contact_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic make_ni,
  input  logic break_ni,
  output logic pressed_o
);
  logic                   state_q;
  logic [SYNC_STAGES-1:0] sync_q;

  // set/reset element: holds on transit (both high) and on illegal (both low)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   state_q <= 1'b0;
    else if (!make_ni && break_ni) state_q <= 1'b1;
    else if (make_ni && !break_ni) state_q <= 1'b0;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= state_q;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], state_q};
      end
    end
  endgenerate

  assign pressed_o = sync_q[SYNC_STAGES-1];

  // R4
  hold_transit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (make_ni && break_ni) |=> $stable(state_q));
  // R4
  hold_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!make_ni && !break_ni) |=> $stable(state_q));
endmodule

// File: rtl/fp_press_pulse.sv
module fp_press_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic halted_i,
  output logic pulse_o
);
  logic prev_q, pulse_q;

  // history always tracks the level, so a press masked while running is consumed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= level_i;
      pulse_q <= level_i & ~prev_q & halted_i;
    end
  end

  assign pulse_o = pulse_q;

  // R2
  one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  // R5
  level_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> prev_q);
endmodule

// File: rtl/fp_run_ctrl.sv
module fp_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic step_i,
  input  logic instr_end_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    run_q <= 1'b0;
    else if (clr_i)                 run_q <= 1'b0;
    else if (set_i)                 run_q <= 1'b1;
    else if (step_i && instr_end_i) run_q <= 1'b0;
  end

  assign run_o = run_q;

  // R7
  cont_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> run_q);
  // R8
  step_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && instr_end_i && !set_i) |=> !run_q);
  // R8
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !clr_i && !instr_end_i) |=> run_q);
endmodule

// File: rtl/fp_ctrl_pulse.sv
module fp_ctrl_pulse
  import fp_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_make_ni,
  input  logic clr_break_ni,
  input  logic cont_make_ni,
  input  logic cont_break_ni,
  input  logic step_i,
  input  logic instr_end_i,
  output logic clr_pulse_no,
  output logic clr_pulse_o,
  output logic cont_pulse_no,
  output logic run_o
);
  logic [NUM_BTN-1:0] make_n, break_n, level, pulse;
  logic               run;

  assign make_n[BTN_CLR]   = clr_make_ni;
  assign break_n[BTN_CLR]  = clr_break_ni;
  assign make_n[BTN_CONT]  = cont_make_ni;
  assign break_n[BTN_CONT] = cont_break_ni;

  generate
    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
      fp_contact_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .make_ni  (make_n[b]),
        .break_ni (break_n[b]),
        .pressed_o(level[b])
      );
      fp_press_pulse u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (level[b]),
        .halted_i(~run),
        .pulse_o (pulse[b])
      );
    end
  endgenerate

  fp_run_ctrl u_run (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (pulse[BTN_CONT]),
    .clr_i      (pulse[BTN_CLR]),
    .step_i     (step_i),
    .instr_end_i(instr_end_i),
    .run_o      (run)
  );

  assign clr_pulse_o   = pulse[BTN_CLR];
  assign clr_pulse_no  = ~pulse[BTN_CLR];
  assign cont_pulse_no = ~pulse[BTN_CONT];
  assign run_o         = run;

  // R6
  gated_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse[BTN_CLR] || pulse[BTN_CONT]) |-> !run);
  // R6
  clr_no_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !instr_end_i) |=> run_o);
endmodule

// File: tb/fp_ctrl_pulse_test.sv
module fp_ctrl_pulse_test;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_make_ni = 1'b1, clr_break_ni = 1'b0;
  logic cont_make_ni = 1'b1, cont_break_ni = 1'b0;
  logic step_i = 1'b0, instr_end_i = 1'b0;
  logic clr_pulse_no, clr_pulse_o, cont_pulse_no, run_o;

  int checks = 0, errors = 0;
  int clr_seen = 0, cont_seen = 0, compl_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_ctrl_pulse #(.SYNC_STAGES(SYNC)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .clr_make_ni(clr_make_ni), .clr_break_ni(clr_break_ni),
    .cont_make_ni(cont_make_ni), .cont_break_ni(cont_break_ni),
    .step_i(step_i), .instr_end_i(instr_end_i),
    .clr_pulse_no(clr_pulse_no), .clr_pulse_o(clr_pulse_o),
    .cont_pulse_no(cont_pulse_no), .run_o(run_o)
  );

  always @(negedge clk) begin
    if (clr_pulse_o)                   clr_seen++;
    if (!cont_pulse_no)                cont_seen++;
    if (clr_pulse_no !== ~clr_pulse_o) compl_bad++;
  end

  typedef struct packed {
    logic       is_clr;
    logic [2:0] bounces;
    logic [1:0] exp_clr;
    logic [1:0] exp_cont;
    logic       exp_run;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 2'd1, 2'd0, 1'b0},
    '{1'b1, 3'd3, 2'd1, 2'd0, 1'b0},
    '{1'b0, 3'd0, 2'd0, 2'd1, 1'b1},
    '{1'b1, 3'd2, 2'd1, 2'd0, 1'b0},
    '{1'b0, 3'd5, 2'd0, 2'd1, 1'b1},
    '{1'b1, 3'd1, 2'd1, 2'd0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit is_clr, input logic mk, input logic br);
    if (is_clr) begin clr_make_ni = mk; clr_break_ni = br; end
    else        begin cont_make_ni = mk; cont_break_ni = br; end
  endtask

  task automatic press(input bit is_clr, input int bounces);
    for (int b = 0; b < bounces; b++) begin
      drive(is_clr, 1'b0, 1'b1); tick(1);
      drive(is_clr, 1'b1, 1'b1); tick(1);
    end
    drive(is_clr, 1'b0, 1'b1);
  endtask

  task automatic release_btn(input bit is_clr);
    drive(is_clr, 1'b1, 1'b1); tick(1);
    drive(is_clr, 1'b1, 1'b0); tick(8);
  endtask

  task automatic halt();
    step_i = 1'b1; instr_end_i = 1'b1; tick(1);
    step_i = 1'b0; instr_end_i = 1'b0; tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0, k0, lat;
    tick(3);
    // R1 reset values
    check(run_o == 1'b0 && clr_pulse_o == 1'b0 && clr_pulse_no == 1'b1 && cont_pulse_no == 1'b1,
          "R1 in reset", {run_o, clr_pulse_o, clr_pulse_no, cont_pulse_no}, 4'b0011);
    rst_ni = 1'b1; tick(4);
    check(run_o == 1'b0 && clr_pulse_o == 1'b0 && clr_pulse_no == 1'b1 && cont_pulse_no == 1'b1,
          "R1 after reset", {run_o, clr_pulse_o, clr_pulse_no, cont_pulse_no}, 4'b0011);

    // vector table, R2 R3 R4 R7
    for (int v = 0; v < NV; v++) begin
      c0 = clr_seen; k0 = cont_seen;
      press(VEC[v].is_clr, int'(VEC[v].bounces));
      tick(10);
      check(run_o == VEC[v].exp_run, "R7 table run", run_o, VEC[v].exp_run);
      release_btn(VEC[v].is_clr);
      check(clr_seen - c0 == int'(VEC[v].exp_clr), "R2 R4 table clear pulses", clr_seen - c0, VEC[v].exp_clr);
      check(cont_seen - k0 == int'(VEC[v].exp_cont), "R3 R4 table continue pulses", cont_seen - k0, VEC[v].exp_cont);
      if (run_o) halt();
      check(run_o == 1'b0, "R8 table halt", run_o, 0);
    end

    // R2 exact latency and width of clear pulse
    lat = -1;
    press(1'b1, 0);
    for (int i = 1; i <= LAT + 2; i++) begin
      tick(1);
      if (clr_pulse_o && lat < 0) lat = i;
      if (i == LAT) check(clr_pulse_o == 1'b1 && clr_pulse_no == 1'b0, "R2 pulse at latency", clr_pulse_o, 1);
      if (i == LAT + 1) check(clr_pulse_o == 1'b0 && clr_pulse_no == 1'b1, "R2 pulse width", clr_pulse_o, 0);
    end
    check(lat == LAT, "R2 latency", lat, LAT);
    release_btn(1'b1);

    // R3 and R7 exact timing of continue pulse and run
    press(1'b0, 0);
    tick(LAT - 1);
    check(cont_pulse_no == 1'b1, "R3 no early pulse", cont_pulse_no, 1);
    tick(1);
    check(cont_pulse_no == 1'b0 && run_o == 1'b0, "R3 pulse at latency", cont_pulse_no, 0);
    tick(1);
    check(cont_pulse_no == 1'b1 && run_o == 1'b1, "R7 run set next edge", run_o, 1);
    release_btn(1'b0);

    // R6 clear while running: no pulse, run kept
    c0 = clr_seen;
    press(1'b1, 0); tick(12);
    check(run_o == 1'b1, "R6 clear cannot stop run", run_o, 1);
    check(clr_seen == c0, "R6 clear masked while running", clr_seen - c0, 0);
    // R8 step alone does nothing, step with end-of-instruction halts
    step_i = 1'b1; tick(5);
    check(run_o == 1'b1, "R8 step without end", run_o, 1);
    instr_end_i = 1'b1; tick(1);
    check(run_o == 1'b0, "R8 step halt", run_o, 0);
    instr_end_i = 1'b0; step_i = 1'b0;
    tick(10);
    check(clr_seen == c0, "R6 held button after halt", clr_seen - c0, 0);
    release_btn(1'b1);
    press(1'b1, 0); tick(10);
    check(clr_seen == c0 + 1, "R6 repress after halt", clr_seen - c0, 1);

    // R5 long hold
    tick(40);
    check(clr_seen == c0 + 1, "R5 long hold one pulse", clr_seen - c0, 1);
    // R4 illegal pair while pressed holds pressed
    drive(1'b1, 1'b0, 1'b0); tick(6);
    drive(1'b1, 1'b0, 1'b1); tick(8);
    check(clr_seen == c0 + 1, "R4 illegal pair holds pressed", clr_seen - c0, 1);
    release_btn(1'b1);
    // R4 illegal pair while released holds released
    c0 = clr_seen;
    drive(1'b1, 1'b0, 1'b0); tick(8);
    check(clr_seen == c0, "R4 illegal pair holds released", clr_seen - c0, 0);
    drive(1'b1, 1'b1, 1'b0); tick(4);

    // R9 repeatability
    c0 = clr_seen;
    for (int n = 0; n < 5; n++) begin
      press(1'b1, n % 3); tick(8);
      release_btn(1'b1);
    end
    check(clr_seen == c0 + 5, "R9 five presses", clr_seen - c0, 5);
    check(compl_bad == 0, "R2 complementary outputs", compl_bad, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule